// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-interrupt state of a parallel peripheral interface with seven internal event sources and combines it into one active-high interrupt request. Each source raises its flag with a one-cycle set pulse. A flag stays set until software clears it. Software clears a flag in one of two ways: it writes a one to that bit of the flag register, or it makes an access elsewhere in the register space that clears the flag as a side effect.

A second register holds one enable bit per source. Bit 7 of a write to this register selects the operation. When bit 7 is one, the other set bits turn their enables on. When bit 7 is zero, the other set bits turn their enables off. The interrupt request is high whenever any flag and its enable are both set.

The register bus is a simple strobe interface. It carries a valid bit, a write bit, a 4-bit address and 8-bit write data. Read data is combinational from the current address. All state changes take effect at the clock edge that ends the access.

Top module: `irq_regs_top`

## Requirements
- R1: After reset all seven flags and all seven enables are zero and `irq_o` is low.
- R2: A one on bit k of `src_set_i` sets flag k at the next clock edge. The bit positions are: bit 0 is the port A control line 2 event, bit 1 is the port A control line 1 event, bit 2 is the shift register event, bit 3 is the port B control line 2 event, bit 4 is the port B control line 1 event, bit 5 is the timer 2 event and bit 6 is the timer 1 event.
- R3: A write to address 13 clears every flag whose bit is one in write data bits 6..0. It leaves the other flags unchanged.
- R4: A write to address 14 with data bit 7 = 1 sets every enable whose bit is one in data bits 6..0. The other enables are kept.
- R5: A write to address 14 with data bit 7 = 0 clears every enable whose bit is one in data bits 6..0. The other enables are kept.
- R6: A read of address 13 returns the flags in bits 6..0, with bit 7 equal to the present value of `irq_o`.
- R7: A read of address 14 returns the enables in bits 6..0, with bit 7 always one.
- R8: A read of address 0 clears flags 4 and 3.
- R9: A read of address 1 or address 15 clears flags 1 and 0.
- R10: Any read or write of address 10 clears flag 2.
- R11: `irq_o` is high exactly when the flags ANDed with the enables are nonzero. It follows every change to either register.
- R12: When a set pulse and a clear of the same flag occur in the same cycle, the flag ends up set.
- R13: Writes to addresses 0, 1 and 15 leave every flag unchanged.
- R14: A read of any address other than 13 or 14 returns zero on `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 7 | One-cycle set pulses from the seven sources |
| bus_valid_i | input | 1 | Register access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the current address |
| irq_o | output | 1 | Combined interrupt request, active high |

## Verification
A source set pulse and a software clear of the same flag can arrive in the same cycle. The clear can come from an explicit write to the flag register or from a side-effect access such as a shift-register read. The bench drives both in one cycle and checks that the flag reads back set and that the request follows the enable. It also covers the paths where only one of the two actions occurs, so that the priority is seen against both of its alternatives.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
    localparam int NSRC = 7;
    localparam int DW   = NSRC + 1;
    localparam int AW   = 4;

    localparam int B_CA2 = 0;
    localparam int B_CA1 = 1;
    localparam int B_SHF = 2;
    localparam int B_CB2 = 3;
    localparam int B_CB1 = 4;
    localparam int B_TM2 = 5;
    localparam int B_TM1 = 6;

    localparam logic [AW-1:0] A_PORTB  = 4'd0;
    localparam logic [AW-1:0] A_PORTA  = 4'd1;
    localparam logic [AW-1:0] A_PORTA2 = 4'd15;
    localparam logic [AW-1:0] A_SHIFT  = 4'd10;
    localparam logic [AW-1:0] A_FLAGS  = 4'd13;
    localparam logic [AW-1:0] A_ENABLE = 4'd14;

    typedef logic [NSRC-1:0] srcvec_t;
endpackage

// File: rtl/irq_clear_decode.sv
module irq_clear_decode
    import irq_regs_pkg::*;
(
    input  logic          valid_i,
    input  logic          write_i,
    input  logic [AW-1:0] addr_i,
    input  srcvec_t       wbits_i,
    output srcvec_t       clr_o
);
    always_comb begin
        clr_o = '0;
        if (valid_i) begin
            if (write_i && addr_i == A_FLAGS) begin
                clr_o = wbits_i;
            end
            if (!write_i && addr_i == A_PORTB) begin
                clr_o[B_CB1] = 1'b1;
                clr_o[B_CB2] = 1'b1;
            end
            if (!write_i && (addr_i == A_PORTA || addr_i == A_PORTA2)) begin
                clr_o[B_CA1] = 1'b1;
                clr_o[B_CA2] = 1'b1;
            end
            if (addr_i == A_SHIFT) begin
                clr_o[B_SHF] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_flag_store.sv
module irq_flag_store
    import irq_regs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  srcvec_t set_i,
    input  srcvec_t clr_i,
    output srcvec_t flags_o
);
    typedef struct packed {
        srcvec_t flags;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/irq_enable_store.sv
module irq_enable_store
    import irq_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output srcvec_t       en_o
);
    typedef struct packed {
        srcvec_t en;
    } estate_t;

    estate_t st_d, st_q;
    srcvec_t sel;

    always_comb begin
        sel  = wdata_i[NSRC-1:0];
        st_d = st_q;
        if (wr_i) begin
            if (wdata_i[DW-1]) st_d.en = st_q.en | sel;
            else               st_d.en = st_q.en & ~sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[DW-1]) |=>
            ((en_o & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));

    assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[DW-1]) |=> ((en_o & $past(wdata_i[NSRC-1:0])) == '0));

    assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irq_regs_top.sv
module irq_regs_top
    import irq_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [6:0]    src_set_i,
    input  logic          bus_valid_i,
    input  logic          bus_write_i,
    input  logic [3:0]    bus_addr_i,
    input  logic [7:0]    bus_wdata_i,
    output logic [7:0]    rd_data_o,
    output logic          irq_o
);
    srcvec_t clr_w;
    srcvec_t flags_w;
    srcvec_t en_w;
    logic    en_wr;

    assign en_wr = bus_valid_i && bus_write_i && bus_addr_i == A_ENABLE;

    irq_clear_decode u_clr (
        .valid_i (bus_valid_i),
        .write_i (bus_write_i),
        .addr_i  (bus_addr_i),
        .wbits_i (bus_wdata_i[NSRC-1:0]),
        .clr_o   (clr_w)
    );

    irq_flag_store u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_set_i),
        .clr_i   (clr_w),
        .flags_o (flags_w)
    );

    irq_enable_store u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (bus_wdata_i),
        .en_o    (en_w)
    );

    assign irq_o = |(flags_w & en_w);

    always_comb begin
        rd_data_o = '0;
        if (bus_valid_i && !bus_write_i) begin
            case (bus_addr_i)
                A_FLAGS:  rd_data_o = {irq_o, flags_w};
                A_ENABLE: rd_data_o = {1'b1, en_w};
                default:  rd_data_o = '0;
            endcase
        end
    end

    assert_rd_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i && bus_addr_i == A_FLAGS) |-> (rd_data_o[7] == irq_o));

    assert_rd_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i && bus_addr_i == A_ENABLE) |-> rd_data_o[7]);

    assert_en_kills_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w == '0) |-> !irq_o);
endmodule

// File: tb/irq_regs_top_tb.sv
`timescale 1ns/1ps
module irq_regs_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_set_i = '0;
    logic       bus_valid_i = 1'b0;
    logic       bus_write_i = 1'b0;
    logic [3:0] bus_addr_i = '0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int  n_checks = 0;
    int  n_errs = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    irq_regs_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_set_i(src_set_i),
        .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // {set, valid, write, addr, wdata, expected read of 13, expected read of 14}
    localparam logic [36:0] VECS [0:12] = '{
        {7'h7F, 1'b0, 1'b0, 4'd0,  8'h00, 8'h7F, 8'h80}, // R2 all set
        {7'h00, 1'b1, 1'b1, 4'd14, 8'hC1, 8'hFF, 8'hC1}, // R4 R11
        {7'h00, 1'b1, 1'b1, 4'd13, 8'h01, 8'hFE, 8'hC1}, // R3
        {7'h00, 1'b1, 1'b0, 4'd0,  8'h00, 8'hE6, 8'hC1}, // R8
        {7'h00, 1'b1, 1'b0, 4'd15, 8'h00, 8'hE4, 8'hC1}, // R9 alt address
        {7'h00, 1'b1, 1'b1, 4'd10, 8'h00, 8'hE0, 8'hC1}, // R10 write
        {7'h00, 1'b1, 1'b1, 4'd14, 8'h40, 8'h60, 8'h81}, // R5 R11
        {7'h00, 1'b1, 1'b1, 4'd1,  8'hFF, 8'h60, 8'h81}, // R13
        {7'h01, 1'b1, 1'b1, 4'd13, 8'h01, 8'hE1, 8'h81}, // R12 explicit clear
        {7'h04, 1'b1, 1'b0, 4'd10, 8'h00, 8'hE5, 8'h81}, // R12 side-effect clear
        {7'h00, 1'b1, 1'b0, 4'd1,  8'h00, 8'h64, 8'h81}, // R9 R11
        {7'h00, 1'b1, 1'b1, 4'd13, 8'hFF, 8'h00, 8'h81}, // R3 all
        {7'h00, 1'b1, 1'b1, 4'd14, 8'hFF, 8'h00, 8'hFF}  // R4 all
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R2";   1: return "R4";   2: return "R3";
            3: return "R8";   4: return "R9";   5: return "R10";
            6: return "R5";   7: return "R13";  8: return "R12";
            9: return "R12";  10: return "R9";  11: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(logic [6:0] s, logic v, logic w, logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        src_set_i = s; bus_valid_i = v; bus_write_i = w; bus_addr_i = a; bus_wdata_i = d;
        @(posedge clk);
        #1;
        src_set_i = '0; bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    endtask

    task automatic peek(logic [3:0] a, output logic [7:0] r);
        bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
        #0.2;
        r = rd_data_o;
        bus_valid_i = 1'b0; bus_addr_i = '0;
        #0.1;
    endtask

    initial begin
        logic [7:0] r13, r14;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        peek(4'd13, r13); check("R1 flags", r13, 8'h00);
        peek(4'd14, r14); check("R1 enables", r14, 8'h80);
        check("R1 irq", {7'd0, irq_o}, 8'h00);

        for (int i = 0; i < 13; i++) begin
            step(VECS[i][36:30], VECS[i][29], VECS[i][28], VECS[i][27:24], VECS[i][23:16]);
            peek(4'd13, r13); check({vec_req(i), " R6 flag read"}, r13, VECS[i][15:8]);
            peek(4'd14, r14); check({vec_req(i), " R7 enable read"}, r14, VECS[i][7:0]);
            check({vec_req(i), " R11 irq"}, {7'd0, irq_o}, {7'd0, VECS[i][15]});
        end

        // R2: each bit position alone; enables are all on, so irq follows (R11)
        for (int k = 0; k < 7; k++) begin
            step(7'(1 << k), 1'b0, 1'b0, 4'd0, 8'h00);
            peek(4'd13, r13); check("R2 bit position", r13, 8'h80 | 8'(1 << k));
            step(7'h00, 1'b1, 1'b1, 4'd13, 8'h7F);
            peek(4'd13, r13); check("R3 clear back", r13, 8'h00);
        end

        // R14: other addresses read zero even with state present
        step(7'h7F, 1'b0, 1'b0, 4'd0, 8'h00);
        peek(4'd5, r13); check("R14 other read", r13, 8'h00);
        peek(4'd12, r13); check("R14 other read", r13, 8'h00);

        // R13: writes to address 0 and 15 do not clear
        step(7'h00, 1'b1, 1'b1, 4'd0, 8'hFF);
        step(7'h00, 1'b1, 1'b1, 4'd15, 8'hFF);
        peek(4'd13, r13); check("R13 write no clear", r13, 8'hFF);

        // R1: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        peek(4'd13, r13); check("R1 reset flags", r13, 8'h00);
        peek(4'd14, r14); check("R1 reset enables", r14, 8'h80);
        check("R1 reset irq", {7'd0, irq_o}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule